// File: doc/BRIEF.md
# Microcode Routing Decoder

This block turns the routing fields of a micro-instruction into datapath control for a small byte-wide processor. Each cycle it chooses the byte on the internal data bus and forms the 16-bit memory address from one of four addressing modes. It also raises a one-hot write enable for the destination named by the micro-instruction. The byte-wide working registers live inside the block: the temporary T, the accumulator A, the pointer pair DPH:DPL and the program counter. When a destination write enable and the cycle-valid strobe are both high, the internal registers load the result bus from the ALU at the clock edge. Memory, video RAM and the output port are external. Their write enables are presented at the block's edge for the surrounding logic.

The source bit is decoded in two ways, depending on the destination. For the memory and output destinations it chooses between an immediate byte, taken from the lower control byte, and the operand bus. For every other destination it chooses between one byte of the current address and the memory read data. Register-area addressing reaches a fixed window of memory. Half of that window has two banks, and a toggle flip-flop picks which bank is in use, so a single strobe swaps in a complete alternate register set.

Top module: `uop_route_decoder`

## Requirements
- R1: `dst_we` is one-hot, with bit k set for destination code k (0 T, 1 DPH, 2 DPL, 3 memory, 4 A, 5 PCH, 6 video RAM, 7 output), and it is all zero while `cyc_valid` is low.
- R2: For destination 3 or 7, `data_bus` carries `ctl_low` when `ctl_src`=0 and `operand` when `ctl_src`=1.
- R3: For any other destination, `data_bus` carries `mem_rdata` when `ctl_src`=1. When `ctl_src`=0 it carries `addr[15:8]` if `ctl_low[3]`=1, and `addr[7:0]` otherwise.
- R4: The value of `ctl_mode` sets `addr`: 3 gives {DPH,DPL}, 2 gives the program counter, 1 gives {0,DPL}, and 0 gives {0, REG_BASE+index} modulo 256.
- R5: With `ctl_low[3]`=0, the register index is `ctl_low[2:0]`. With `ctl_low[3]`=1 it is 16 + 8*bank + `ctl_low[2:0]`, where bank is the exchange flip-flop.
- R6: When `cyc_valid` is high and `ctl_mode`=2, the program counter increments by one at the clock edge, wrapping at 16 bits, unless that cycle writes PCH. In every other case it holds.
- R7: A valid write to destination 5 loads PCH from `result` and, at the same edge, loads PCL from the previous DPH.
- R8: The exchange flip-flop inverts on every clock edge at which `xchg` is high, and holds otherwise.
- R9: `operand` carries A when `ctl_low[7]`=1 and T when `ctl_low[7]`=0.
- R10: Synchronous reset clears T, A, DPH, DPL, the program counter and the exchange flip-flop.
- R11: A valid write to destination 0, 1, 2 or 4 loads `result` into T, DPH, DPL or A respectively. No internal register changes when `cyc_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_valid | input | 1 | Micro-instruction in this cycle is live |
| xchg | input | 1 | Toggle the alternate register bank |
| ctl_src | input | 1 | Source select bit |
| ctl_dst | input | 3 | Destination code |
| ctl_mode | input | 2 | Address mode |
| ctl_low | input | 8 | Lower control byte (immediate, operand select, high select, register index) |
| mem_rdata | input | 8 | Memory read data |
| result | input | 8 | ALU result bus written to destinations |
| data_bus | output | 8 | Selected source byte |
| operand | output | 8 | Operand bus (A or T) |
| addr | output | 16 | Memory address |
| dst_we | output | 8 | One-hot destination write enables |

## Verification
The assertions assume that `rst` is held for at least one clock edge before any check. They also assume that every control field is a defined 0/1 value at each edge. Any bit pattern of the control fields is otherwise legal, so the one-hot, counter and toggle properties hold without further limits on the inputs. The stimulus drives every field from the bench on the falling edge, always with known values. It sweeps every destination, source, mode and validity combination, varies the lower byte, and pulses `xchg` at irregular intervals so that both banks are addressed.

// File: rtl/uop_route_pkg.sv
package uop_route_pkg;
  localparam int unsigned DST_W = 3;
  localparam int unsigned N_DST = 1 << DST_W;

  localparam logic [DST_W-1:0] DST_T    = 3'd0;
  localparam logic [DST_W-1:0] DST_DPH  = 3'd1;
  localparam logic [DST_W-1:0] DST_DPL  = 3'd2;
  localparam logic [DST_W-1:0] DST_MEM  = 3'd3;
  localparam logic [DST_W-1:0] DST_A    = 3'd4;
  localparam logic [DST_W-1:0] DST_PCH  = 3'd5;
  localparam logic [DST_W-1:0] DST_VRAM = 3'd6;
  localparam logic [DST_W-1:0] DST_OUT  = 3'd7;

  localparam logic [1:0] AM_REGS = 2'd0;
  localparam logic [1:0] AM_ZP   = 2'd1;
  localparam logic [1:0] AM_PC   = 2'd2;
  localparam logic [1:0] AM_FULL = 2'd3;

  localparam int unsigned IDX_W = DST_W + 2;
endpackage

// File: rtl/uop_route_dst_dec.sv
module uop_route_dst_dec
  import uop_route_pkg::*;
(
  input  logic             valid,
  input  logic [DST_W-1:0] code,
  output logic [N_DST-1:0] we
);
  for (genvar g = 0; g < N_DST; g++) begin : g_we
    assign we[g] = valid && (code == DST_W'(g));
  end
endmodule

// File: rtl/uop_route_state.sv
module uop_route_state
  import uop_route_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_DST-1:0] we,
  input  logic [DW-1:0]   result,
  input  logic            pc_inc,
  input  logic            xchg,
  output logic [DW-1:0]   t_q,
  output logic [DW-1:0]   a_q,
  output logic [DW-1:0]   dph_q,
  output logic [DW-1:0]   dpl_q,
  output logic [2*DW-1:0] pc_q,
  output logic            xbit_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      t_q    <= '0;
      a_q    <= '0;
      dph_q  <= '0;
      dpl_q  <= '0;
      pc_q   <= '0;
      xbit_q <= 1'b0;
    end else begin
      if (we[DST_T])   t_q   <= result;
      if (we[DST_A])   a_q   <= result;
      if (we[DST_DPH]) dph_q <= result;
      if (we[DST_DPL]) dpl_q <= result;
      // a PCH load (with PCL from the old DPH) overrides the increment
      if (we[DST_PCH])   pc_q <= {result, dph_q};
      else if (pc_inc)   pc_q <= pc_q + 1'b1;
      if (xchg) xbit_q <= ~xbit_q;
    end
  end
endmodule

// File: rtl/uop_route_addr.sv
module uop_route_addr
  import uop_route_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter logic [DW-1:0] REG_BASE = 8'hE0
) (
  input  logic [1:0]      mode,
  input  logic            hi,
  input  logic [2:0]      rsel,
  input  logic            xbit,
  input  logic [DW-1:0]   dph,
  input  logic [DW-1:0]   dpl,
  input  logic [2*DW-1:0] pc,
  output logic [2*DW-1:0] addr
);
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    reg_lo;

  // banked upper half: 16 + 8*bank + index; lower half: index
  assign idx    = {hi, hi & xbit, rsel};
  assign reg_lo = REG_BASE + DW'(idx);

  always_comb begin
    unique case (mode)
      AM_REGS: addr = {{DW{1'b0}}, reg_lo};
      AM_ZP:   addr = {{DW{1'b0}}, dpl};
      AM_PC:   addr = pc;
      default: addr = {dph, dpl};
    endcase
  end
endmodule

// File: rtl/uop_route_decoder.sv
module uop_route_decoder
  import uop_route_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter logic [DW-1:0] REG_BASE = 8'hE0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_valid,
  input  logic             xchg,
  input  logic             ctl_src,
  input  logic [DST_W-1:0] ctl_dst,
  input  logic [1:0]       ctl_mode,
  input  logic [DW-1:0]    ctl_low,
  input  logic [DW-1:0]    mem_rdata,
  input  logic [DW-1:0]    result,
  output logic [DW-1:0]    data_bus,
  output logic [DW-1:0]    operand,
  output logic [2*DW-1:0]  addr,
  output logic [N_DST-1:0] dst_we
);
  localparam int unsigned ACC_BIT = DW - 1;
  localparam int unsigned HI_BIT  = 3;

  logic [DW-1:0]   t_q, a_q, dph_q, dpl_q;
  logic [2*DW-1:0] pc_q;
  logic            xbit_q;
  logic            pc_inc;
  logic            to_ext;

  uop_route_dst_dec u_dec (
    .valid (cyc_valid),
    .code  (ctl_dst),
    .we    (dst_we)
  );

  assign pc_inc = cyc_valid && (ctl_mode == AM_PC);

  uop_route_state #(.DW(DW)) u_state (
    .clk    (clk),
    .rst    (rst),
    .we     (dst_we),
    .result (result),
    .pc_inc (pc_inc),
    .xchg   (xchg),
    .t_q    (t_q),
    .a_q    (a_q),
    .dph_q  (dph_q),
    .dpl_q  (dpl_q),
    .pc_q   (pc_q),
    .xbit_q (xbit_q)
  );

  uop_route_addr #(.DW(DW), .REG_BASE(REG_BASE)) u_addr (
    .mode (ctl_mode),
    .hi   (ctl_low[HI_BIT]),
    .rsel (ctl_low[2:0]),
    .xbit (xbit_q),
    .dph  (dph_q),
    .dpl  (dpl_q),
    .pc   (pc_q),
    .addr (addr)
  );

  assign operand = ctl_low[ACC_BIT] ? a_q : t_q;
  assign to_ext  = (ctl_dst == DST_MEM) || (ctl_dst == DST_OUT);

  always_comb begin
    if (to_ext)
      data_bus = ctl_src ? operand : ctl_low;
    else if (ctl_src)
      data_bus = mem_rdata;
    else
      data_bus = ctl_low[HI_BIT] ? addr[2*DW-1:DW] : addr[DW-1:0];
  end
endmodule

// File: rtl/uop_route_checker.sv
module uop_route_checker
  import uop_route_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cyc_valid,
  input logic             xchg,
  input logic [DST_W-1:0] ctl_dst,
  input logic [1:0]       ctl_mode,
  input logic [N_DST-1:0] dst_we,
  input logic [2*DW-1:0]  pc_q,
  input logic [DW-1:0]    dph_q,
  input logic             xbit_q
);
  a_r1_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dst_we));
  a_r1_idle: assert property (@(posedge clk) disable iff (rst)
    !cyc_valid |-> (dst_we == '0));
  a_r6_pc_step: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && ctl_mode == AM_PC && ctl_dst != DST_PCH) |=> (pc_q == $past(pc_q) + 1'b1));
  a_r6_pc_hold: assert property (@(posedge clk) disable iff (rst)
    (!cyc_valid || (ctl_mode != AM_PC && ctl_dst != DST_PCH)) |=> $stable(pc_q));
  a_r7_pcl_from_dph: assert property (@(posedge clk) disable iff (rst)
    dst_we[DST_PCH] |=> (pc_q[DW-1:0] == $past(dph_q)));
  a_r8_toggle: assert property (@(posedge clk) disable iff (rst)
    xchg |=> (xbit_q != $past(xbit_q)));
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !xchg |=> $stable(xbit_q));
endmodule

bind uop_route_decoder uop_route_checker #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cyc_valid (cyc_valid),
  .xchg      (xchg),
  .ctl_dst   (ctl_dst),
  .ctl_mode  (ctl_mode),
  .dst_we    (dst_we),
  .pc_q      (pc_q),
  .dph_q     (dph_q),
  .xbit_q    (xbit_q)
);

// File: tb/uop_route_decoder_bench.sv
module uop_route_decoder_bench;
  localparam logic [7:0] BASE = 8'hE0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_valid = 1'b0, xchg = 1'b0, ctl_src = 1'b0;
  logic [2:0] ctl_dst = '0;
  logic [1:0] ctl_mode = '0;
  logic [7:0] ctl_low = '0, mem_rdata = '0, result = '0;
  logic [7:0] data_bus, operand;
  logic [15:0] addr;
  logic [7:0] dst_we;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  logic [7:0] m_t, m_a, m_dph, m_dpl;
  logic [15:0] m_pc;
  logic m_x;

  always #4 clk = ~clk;

  uop_route_decoder #(.DW(8), .REG_BASE(BASE)) u_uop_route_decoder (
    .clk(clk), .rst(rst), .cyc_valid(cyc_valid), .xchg(xchg),
    .ctl_src(ctl_src), .ctl_dst(ctl_dst), .ctl_mode(ctl_mode),
    .ctl_low(ctl_low), .mem_rdata(mem_rdata), .result(result),
    .data_bus(data_bus), .operand(operand), .addr(addr), .dst_we(dst_we)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_addr(input logic [1:0] mode, input logic [7:0] low);
    int idx;
    idx = low[3] ? (16 + 8 * int'(m_x) + int'(low[2:0])) : int'(low[2:0]);
    case (mode)
      2'd0: return {8'h00, 8'((int'(BASE) + idx) % 256)};
      2'd1: return {8'h00, m_dpl};
      2'd2: return m_pc;
      default: return {m_dph, m_dpl};
    endcase
  endfunction

  task automatic step(input logic v, input logic s, input logic [2:0] d, input logic [1:0] m,
                      input logic [7:0] low, input logic [7:0] rd, input logic [7:0] res,
                      input logic xc);
    logic [15:0] ea;
    logic [7:0] eop, edb, ewe;
    @(negedge clk);
    cyc_valid = v; ctl_src = s; ctl_dst = d; ctl_mode = m;
    ctl_low = low; mem_rdata = rd; result = res; xchg = xc;
    #1;
    ea  = exp_addr(m, low);
    eop = low[7] ? m_a : m_t;
    if (d == 3'd3 || d == 3'd7) edb = s ? eop : low;
    else if (s) edb = rd;
    else edb = low[3] ? ea[15:8] : ea[7:0];
    ewe = v ? (8'd1 << d) : 8'd0;
    check(m == 2'd0 ? "R4/R5 addr" : "R4 addr", 32'(addr), 32'(ea));
    check("R9 operand", 32'(operand), 32'(eop));
    check((d == 3'd3 || d == 3'd7) ? "R2 data_bus" : "R3 data_bus", 32'(data_bus), 32'(edb));
    check("R1 dst_we", 32'(dst_we), 32'(ewe));
    @(posedge clk);
    if (v) begin
      case (d)
        3'd0: m_t = res;
        3'd1: m_dph = res;
        3'd2: m_dpl = res;
        3'd4: m_a = res;
        3'd5: m_pc = {res, m_dph};  // R7
        default: ;
      endcase
      if (m == 2'd2 && d != 3'd5) m_pc = m_pc + 16'd1;  // R6
    end
    if (xc) m_x = ~m_x;  // R8
  endtask

  initial begin
    m_t = 0; m_a = 0; m_dph = 0; m_dpl = 0; m_pc = 0; m_x = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: reset state seen through the ports
    ctl_mode = 2'd3; ctl_low = 8'h80; #1;
    check("R10 dp after reset", 32'(addr), 32'h0);
    check("R10 A after reset", 32'(operand), 32'h0);
    ctl_mode = 2'd2; ctl_low = 8'h00; #1;
    check("R10 pc after reset", 32'(addr), 32'h0);
    check("R10 T after reset", 32'(operand), 32'h0);
    ctl_mode = 2'd0; ctl_low = 8'h08; #1;
    check("R10/R5 bank after reset", 32'(addr), 32'(BASE + 8'd16));
    check("R1 no enable at idle", 32'(dst_we), 32'h0);

    // R11 and R7: explicit load sequence
    step(1, 0, 3'd1, 2'd1, 8'h00, 8'h00, 8'h12, 0);  // DPH=12
    step(1, 0, 3'd2, 2'd1, 8'h00, 8'h00, 8'h34, 0);  // DPL=34
    step(1, 0, 3'd5, 2'd3, 8'h00, 8'h00, 8'hAB, 0);  // PC=AB12
    step(0, 0, 3'd2, 2'd2, 8'h00, 8'h00, 8'hFF, 0);
    check("R7 pc after PCH load", 32'(addr), 32'hAB12);
    step(1, 0, 3'd5, 2'd2, 8'h00, 8'h00, 8'h77, 0);  // PCH wins over increment
    step(0, 0, 3'd0, 2'd2, 8'h00, 8'h00, 8'h00, 0);
    check("R7 PCH beats increment", 32'(addr), 32'h7712);
    step(1, 0, 3'd4, 2'd3, 8'h00, 8'h00, 8'h5A, 0);  // A
    step(1, 0, 3'd0, 2'd3, 8'h00, 8'h00, 8'hC3, 0);  // T
    step(0, 1, 3'd3, 2'd3, 8'h80, 8'h00, 8'h11, 0);
    check("R11 A loaded", 32'(operand), 32'h5A);
    step(0, 1, 3'd7, 2'd3, 8'h00, 8'h00, 8'h22, 0);
    check("R11 T loaded, invalid write ignored", 32'(operand), 32'hC3);

    // PC wrap (R6)
    step(1, 0, 3'd1, 2'd3, 8'h00, 8'h00, 8'hFF, 0);
    step(1, 0, 3'd5, 2'd3, 8'h00, 8'h00, 8'hFF, 0);  // PC=FFFF
    step(1, 0, 3'd6, 2'd2, 8'h00, 8'h00, 8'h00, 0);  // increments
    step(0, 0, 3'd0, 2'd2, 8'h00, 8'h00, 8'h00, 0);
    check("R6 pc wraps", 32'(addr), 32'h0);

    // sweep over every field combination
    begin
      int n = 0;
      for (int k = 0; k < 4; k++)
        for (int v = 0; v < 2; v++)
          for (int d = 0; d < 8; d++)
            for (int s = 0; s < 2; s++)
              for (int m = 0; m < 4; m++) begin
                n++;
                step(v[0], s[0], d[2:0], m[1:0], 8'((n * 37 + k * 5 + 11) % 256),
                     8'((n * 53 + 3) % 256), 8'((n * 91 + 5) % 256), (n % 7) == 3);
              end
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule